// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is locked. Two pulses enter it: one for each edge of the divided reference and one for each edge of the divided feedback. Both pulses are one sampling-clock cycle wide and synchronous to the sampling clock. For every phase-detector cycle, the block counts the sampling-clock ticks from whichever edge comes first to the edge that follows it. That count is the phase error. The block grades the error against two thresholds, which are given in ticks. With a 200 MHz sampling clock, a 15 ns acquire limit is 3 ticks and a 25 ns release limit is 5 ticks.

The lock output goes high only after a run of `GOOD_RUN` consecutive cycles (default five) whose error is below the acquire limit. Once high, it stays high until one cycle shows an error above the looser release limit. This gives the detector hysteresis. If the second edge of a cycle never arrives, the measurement gives up after `TIMEOUT_TICKS` ticks and the cycle counts as a gross error. Control and status pins are plain levels, and there is no streaming interface and no back-pressure.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous reset drives `locked` low and empties the count of consecutive good cycles, whatever the lock state before it.
- R2: `locked` is active high. It rises one clock after the measurement of the `GOOD_RUN`-th consecutive cycle whose error is strictly less than `acq_limit`, and not before.
- R3: The error of a cycle is the number of sampling-clock ticks from the first-arriving pulse to the other pulse, in either order. Pulses in the same clock give an error of 0.
- R4: While unlocked, any cycle whose error is at or above `acq_limit` clears the consecutive count, so a full new run of `GOOD_RUN` good cycles is needed.
- R5: While locked, an error at or below `rel_limit` keeps `locked` high, including errors from `acq_limit` up to `rel_limit`.
- R6: While locked, a single cycle with an error strictly greater than `rel_limit` drops `locked` one clock after its measurement.
- R7: If the second pulse has not arrived within `TIMEOUT_TICKS` ticks of the first, the cycle ends with a saturated error and is treated as exceeding the release limit.
- R8: After lock is lost, a fresh run of `GOOD_RUN` good cycles is needed before `locked` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one tick is one period |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | One-cycle pulse on each divided-reference edge |
| fb_pulse | input | 1 | One-cycle pulse on each divided-feedback edge |
| acq_limit | input | CNT_W | Acquire threshold in ticks; error must be below it |
| rel_limit | input | CNT_W | Release threshold in ticks; error above it drops lock |
| locked | output | 1 | Lock indicator, active high |

## Verification
The assertions check on every clock that the consecutive-good count stays below its target and is zero while locked, and that `locked` rises only right after a good measurement. They also check that a single bad measurement drops `locked`, that a middle-band error keeps it, and that a timed-out cycle unlocks. Only the bench's scenarios can show the end-to-end tick arithmetic. That covers the exact boundary where an error of `acq_limit` stops counting and `rel_limit` still holds, the edge order, coincident edges, and the exact cycle count of acquisition and re-acquisition.

// File: rtl/plm_pkg.sv
package plm_pkg;
  // Measurement state: idle, or waiting for the edge that closes the cycle
  typedef enum logic [1:0] {
    PM_IDLE     = 2'd0,
    PM_WAIT_FB  = 2'd1,
    PM_WAIT_REF = 2'd2
  } pm_state_e;

  // One graded phase-detector cycle
  typedef struct packed {
    logic valid;
    logic good;
    logic bad;
    logic timeout;
  } plm_verdict_t;
endpackage

// File: rtl/plm_phase_meter.sv
module plm_phase_meter #(
  parameter int CNT_W         = 8,
  parameter int TIMEOUT_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             meas_valid,
  output logic             meas_timeout,
  output logic [CNT_W-1:0] meas_err
);
  import plm_pkg::*;

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  pm_state_e        state;
  logic [CNT_W-1:0] tick_cnt;
  logic             closing_edge;

  // The edge that ends the cycle is the opposite of the one that opened it
  always_comb begin
    closing_edge = 1'b0;
    if (state == PM_WAIT_FB)  closing_edge = fb_pulse;
    if (state == PM_WAIT_REF) closing_edge = ref_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= PM_IDLE;
      tick_cnt     <= '0;
      meas_valid   <= 1'b0;
      meas_timeout <= 1'b0;
      meas_err     <= '0;
    end else begin
      meas_valid   <= 1'b0;
      meas_timeout <= 1'b0;
      case (state)
        PM_IDLE: begin
          tick_cnt <= '0;
          if (ref_pulse && fb_pulse) begin
            meas_valid <= 1'b1;
            meas_err   <= '0;
          end else if (ref_pulse) begin
            state <= PM_WAIT_FB;
          end else if (fb_pulse) begin
            state <= PM_WAIT_REF;
          end
        end
        PM_WAIT_FB, PM_WAIT_REF: begin
          if (closing_edge) begin
            meas_valid <= 1'b1;
            meas_err   <= tick_cnt + ONE;
            state      <= PM_IDLE;
          end else if (tick_cnt == LAST_TICK) begin
            meas_valid   <= 1'b1;
            meas_timeout <= 1'b1;
            meas_err     <= '1;
            state        <= PM_IDLE;
          end else begin
            tick_cnt <= tick_cnt + ONE;
          end
        end
        default: state <= PM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plm_grader.sv
module plm_grader #(
  parameter int CNT_W = 8
) (
  input  logic               meas_valid,
  input  logic               meas_timeout,
  input  logic [CNT_W-1:0]   meas_err,
  input  logic [CNT_W-1:0]   acq_limit,
  input  logic [CNT_W-1:0]   rel_limit,
  output plm_pkg::plm_verdict_t verdict
);
  always_comb begin
    verdict.valid   = meas_valid;
    verdict.timeout = meas_timeout;
    verdict.good    = !meas_timeout && (meas_err < acq_limit);
    verdict.bad     = meas_timeout || (meas_err > rel_limit);
  end
endmodule

// File: rtl/plm_lock_fsm.sv
module plm_lock_fsm #(
  parameter int GOOD_RUN = 5,
  parameter int RUN_W    = $clog2(GOOD_RUN + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  plm_pkg::plm_verdict_t verdict,
  output logic                  locked,
  output logic [RUN_W-1:0]      run_cnt
);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      run_cnt <= '0;
    end else if (verdict.valid) begin
      if (!locked) begin
        if (!verdict.good) begin
          run_cnt <= '0;
        end else if (run_cnt == RUN_LAST) begin
          locked  <= 1'b1;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + RUN_ONE;
        end
      end else if (verdict.bad) begin
        locked  <= 1'b0;
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int CNT_W         = 8,
  parameter int GOOD_RUN      = 5,
  parameter int TIMEOUT_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic [CNT_W-1:0] acq_limit,
  input  logic [CNT_W-1:0] rel_limit,
  output logic             locked
);
  localparam int RUN_W = $clog2(GOOD_RUN + 1);

  logic                  meas_valid;
  logic                  meas_timeout;
  logic [CNT_W-1:0]      meas_err;
  plm_pkg::plm_verdict_t verdict;
  logic [RUN_W-1:0]      run_cnt;

  plm_phase_meter #(.CNT_W(CNT_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_meter (
    .clk          (clk),
    .rst          (rst),
    .ref_pulse    (ref_pulse),
    .fb_pulse     (fb_pulse),
    .meas_valid   (meas_valid),
    .meas_timeout (meas_timeout),
    .meas_err     (meas_err)
  );

  plm_grader #(.CNT_W(CNT_W)) u_grader (
    .meas_valid   (meas_valid),
    .meas_timeout (meas_timeout),
    .meas_err     (meas_err),
    .acq_limit    (acq_limit),
    .rel_limit    (rel_limit),
    .verdict      (verdict)
  );

  plm_lock_fsm #(.GOOD_RUN(GOOD_RUN), .RUN_W(RUN_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .verdict (verdict),
    .locked  (locked),
    .run_cnt (run_cnt)
  );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int GOOD_RUN = 5,
  parameter int RUN_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             locked,
  input logic [RUN_W-1:0] run_cnt,
  input logic             meas_valid,
  input logic             meas_timeout,
  input plm_pkg::plm_verdict_t verdict
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!locked && run_cnt == '0));

  assert_rise_after_good_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(verdict.valid && verdict.good));

  assert_run_below_target_R2: assert property (@(posedge clk) disable iff (rst)
    run_cnt < RUN_W'(GOOD_RUN));

  assert_break_clears_run_R4: assert property (@(posedge clk) disable iff (rst)
    (verdict.valid && !locked && !verdict.good) |=> (run_cnt == '0 && !locked));

  assert_band_keeps_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (verdict.valid && locked && !verdict.bad) |=> locked);

  assert_bad_drops_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (verdict.valid && locked && verdict.bad) |=> !locked);

  assert_timeout_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && meas_timeout && locked) |=> !locked);

  assert_locked_run_idle_R8: assert property (@(posedge clk) disable iff (rst)
    locked |-> run_cnt == '0);
endmodule

bind pll_lock_monitor plm_checker #(.GOOD_RUN(GOOD_RUN), .RUN_W(RUN_W)) u_plm_checker (
  .clk          (clk),
  .rst          (rst),
  .locked       (locked),
  .run_cnt      (run_cnt),
  .meas_valid   (meas_valid),
  .meas_timeout (meas_timeout),
  .verdict      (verdict)
);

// File: tb/pll_lock_monitor_test.sv
module pll_lock_monitor_test;
  localparam int CNT_W   = 8;
  localparam int RUN     = 5;
  localparam int TMO     = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 1'b0;
  logic fb_pulse  = 1'b0;
  logic [CNT_W-1:0] acq_limit = 8'd3;   // 15 ns at 5 ns/tick
  logic [CNT_W-1:0] rel_limit = 8'd5;   // 25 ns at 5 ns/tick
  logic locked;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pll_lock_monitor #(.CNT_W(CNT_W), .GOOD_RUN(RUN), .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .acq_limit(acq_limit), .rel_limit(rel_limit), .locked(locked)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: locked=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One phase-detector cycle: the second pulse comes gap ticks after the first
  task automatic pair(input bit ref_first, input int gap);
    @(negedge clk);
    if (gap == 0) begin
      ref_pulse = 1'b1; fb_pulse = 1'b1;
    end else if (ref_first) ref_pulse = 1'b1;
    else fb_pulse = 1'b1;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      ref_pulse = 1'b0; fb_pulse = 1'b0;
      if (i == gap) begin
        if (ref_first) fb_pulse = 1'b1;
        else ref_pulse = 1'b1;
      end
    end
    @(negedge clk);
    ref_pulse = 1'b0; fb_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pairs(input int n, input bit ref_first, input int gap);
    for (int k = 0; k < n; k++) pair(ref_first, gap);
  endtask

  task automatic t_reset();
    do_reset();
    check(locked, 1'b0, "R1 reset state");
    pairs(RUN, 1'b1, 1);
    do_reset();
    check(locked, 1'b0, "R1 reset while locked");
    pairs(RUN - 1, 1'b1, 1);
    check(locked, 1'b0, "R1 run emptied by reset");
  endtask

  task automatic t_acquire();
    do_reset();
    pairs(RUN - 1, 1'b1, 2);
    check(locked, 1'b0, "R2 one short of the run");
    pair(1'b1, 2);
    check(locked, 1'b1, "R2 lock after full run");
  endtask

  task automatic t_order();
    do_reset();
    pairs(RUN, 1'b0, 2);
    check(locked, 1'b1, "R3 feedback first");
    do_reset();
    pairs(RUN, 1'b1, 0);
    check(locked, 1'b1, "R3 coincident edges");
    do_reset();
    pairs(RUN, 1'b0, 3);
    check(locked, 1'b0, "R3 error equal to acquire limit");
  endtask

  task automatic t_break();
    do_reset();
    pairs(RUN - 1, 1'b1, 1);
    pair(1'b0, 3);
    check(locked, 1'b0, "R4 break cycle");
    pairs(RUN - 1, 1'b1, 1);
    check(locked, 1'b0, "R4 count restarted");
    pair(1'b1, 1);
    check(locked, 1'b1, "R4 full new run locks");
  endtask

  task automatic t_band();
    pair(1'b1, 3);
    check(locked, 1'b1, "R5 error at acquire limit");
    pair(1'b0, 4);
    check(locked, 1'b1, "R5 mid band");
    pair(1'b1, 5);
    check(locked, 1'b1, "R5 error at release limit");
  endtask

  task automatic t_drop();
    pair(1'b0, 6);
    check(locked, 1'b0, "R6 error above release limit");
  endtask

  task automatic t_relock();
    pairs(RUN - 1, 1'b1, 0);
    check(locked, 1'b0, "R8 relock needs full run");
    pair(1'b1, 0);
    check(locked, 1'b1, "R8 relocked");
  endtask

  task automatic t_timeout();
    @(negedge clk); ref_pulse = 1'b1;
    @(negedge clk); ref_pulse = 1'b0;
    repeat (TMO + 4) @(negedge clk);
    check(locked, 1'b0, "R7 missing feedback edge");
    pairs(RUN, 1'b1, 1);
    @(negedge clk); fb_pulse = 1'b1;
    @(negedge clk); fb_pulse = 1'b0;
    repeat (TMO + 4) @(negedge clk);
    check(locked, 1'b0, "R7 missing reference edge");
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_order();
    t_break();
    t_band();
    t_drop();
    t_relock();
    t_timeout();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule